// File: doc/BRIEF.md
# Ethernet Destination Address Filter

The filter watches the first six bytes of an incoming Ethernet frame, which carry the destination address. It delivers a single accept or reject verdict for the frame, using three configuration enables, a 48-bit station address and a 64-bit multicast hash mask. Address bytes enter one per valid cycle, first byte first. A separate start marker opens each frame, so the filter can sit next to a receive path that has other work to do between bytes.

The filter classifies each destination as broadcast (all ones), multicast (bit 0 of the first byte set) or unicast (everything else). A unicast destination must match the station address exactly. A multicast destination is looked up in the hash mask. The hash index comes from a CRC-32 that is run bit-serially over the six address bytes as they arrive. Promiscuous mode overrides all of these rules.

Top module: `dst_addr_filter`

## Requirements
- R1: When `promisc_i` is 1 in the cycle of the sixth byte, the verdict is accept for every destination.
- R2: A destination of six 0xFF bytes is broadcast. Outside promiscuous mode it is accepted exactly when `bcast_en_i` is 1, and `mcast_en_i` and the mask have no influence on it.
- R3: A destination that is not broadcast and whose first byte has bit 0 set is multicast. Outside promiscuous mode it is accepted exactly when `mcast_en_i` is 1 and bit `hash_o` of `mcast_mask_i` is 1. Mask byte n is `mcast_mask_i[8n+7:8n]`, so index i picks bit i%8 of byte i/8.
- R4: The hash comes from a CRC that starts at 0xFFFFFFFF and takes each byte least significant bit first. For each bit, carry = CRC[31] XOR data bit; the CRC shifts left by one; if carry is 1, the CRC becomes (CRC XOR 0x04C11DB6) OR 1. `hash_o` holds CRC[31:26] after the sixth byte and is valid while `done_o` is 1.
- R5: Any other destination is accepted, outside promiscuous mode, only when byte k equals `sta_addr_i[8k+7:8k]` for k = 0..5, where byte 0 is the first on the wire.
- R6: `done_o` is high for exactly one cycle, the cycle after the sixth byte is taken. `accept_o` is 0 whenever `done_o` is 0.
- R7: A byte with `byte_valid_i` and `first_i` both 1 starts a new frame as byte 0, even in the middle of a frame. Valid bytes without `first_i` are ignored while no frame is open, and bytes after the sixth are ignored too. Cycles with `byte_valid_i` low do not advance the byte count.
- R8: After reset, `done_o`, `accept_o` and `hash_o` are 0 and no frame is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| promisc_i | input | 1 | Accept all frames |
| bcast_en_i | input | 1 | Accept broadcast frames |
| mcast_en_i | input | 1 | Accept multicast frames that hit the hash mask |
| sta_addr_i | input | 48 | Station address, byte 0 in bits 7:0 |
| mcast_mask_i | input | 64 | Multicast hash mask, bit i for hash index i |
| byte_valid_i | input | 1 | An address byte is present |
| first_i | input | 1 | The present byte is byte 0 of a frame |
| byte_i | input | 8 | Address byte |
| done_o | output | 1 | One-cycle verdict strobe |
| accept_o | output | 1 | Verdict, valid with done_o |
| hash_o | output | 6 | Multicast hash index, valid with done_o |

## Verification
The table of destinations covers several cases. An exact station match is set against misses in the first byte and in the last byte, which separates a full compare from a partial one. Broadcast is tried with each enable alone, which shows that the all-ones case does not leak through the multicast path. Multicast destinations run against a mask with only the hashed bit set and against a mask with every bit except that one set, so a wrong hash index or wrong bit order flips the verdict, and every reported hash is compared with a CRC computed in the bench. Directed tests feed bytes with idle gaps, bytes without a start marker, and a restart in the middle of a frame.

// File: rtl/dst_addr_filter.sv
module dst_addr_filter #(
  parameter logic [31:0] CRC_POLY = 32'h04C11DB6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        promisc_i,
  input  logic        bcast_en_i,
  input  logic        mcast_en_i,
  input  logic [47:0] sta_addr_i,
  input  logic [63:0] mcast_mask_i,
  input  logic        byte_valid_i,
  input  logic        first_i,
  input  logic [7:0]  byte_i,
  output logic        done_o,
  output logic        accept_o,
  output logic [5:0]  hash_o
);

  localparam logic [2:0] LAST = 3'd5;
  localparam logic [2:0] IDLE = 3'd6;

  function automatic logic [31:0] crc_step8(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    logic        cy;
    r = c;
    for (int i = 0; i < 8; i++) begin
      cy = r[31] ^ d[i];
      r  = {r[30:0], 1'b0};
      if (cy) r = (r ^ CRC_POLY) | 32'd1;
    end
    return r;
  endfunction

  logic [2:0]  cnt_q;
  logic [31:0] crc_q;
  logic        bc_q, mc_q, uc_q;
  logic        done_q, acc_q;
  logic [5:0]  hash_q;

  logic        take, last;
  logic [2:0]  pos;
  logic [7:0]  sta_byte;
  logic [31:0] crc_nx;
  logic        bc_nx, mc_nx, uc_nx, verdict;

  assign take = byte_valid_i && (first_i || (cnt_q != 3'd0 && cnt_q <= LAST));
  assign pos  = first_i ? 3'd0 : cnt_q;
  assign last = take && pos == LAST;

  always_comb begin
    case (pos)
      3'd0:    sta_byte = sta_addr_i[7:0];
      3'd1:    sta_byte = sta_addr_i[15:8];
      3'd2:    sta_byte = sta_addr_i[23:16];
      3'd3:    sta_byte = sta_addr_i[31:24];
      3'd4:    sta_byte = sta_addr_i[39:32];
      default: sta_byte = sta_addr_i[47:40];
    endcase
  end

  assign crc_nx = crc_step8(first_i ? 32'hFFFF_FFFF : crc_q, byte_i);
  assign bc_nx  = (first_i || bc_q) && byte_i == 8'hFF;
  assign mc_nx  = first_i ? byte_i[0] : mc_q;
  assign uc_nx  = (first_i || uc_q) && byte_i == sta_byte;

  always_comb begin
    if (promisc_i)  verdict = 1'b1;
    else if (bc_nx) verdict = bcast_en_i;
    else if (mc_nx) verdict = mcast_en_i && mcast_mask_i[crc_nx[31:26]];
    else            verdict = uc_nx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= IDLE;
      crc_q  <= '1;
      bc_q   <= 1'b0;
      mc_q   <= 1'b0;
      uc_q   <= 1'b0;
      done_q <= 1'b0;
      acc_q  <= 1'b0;
      hash_q <= '0;
    end else begin
      done_q <= last;
      acc_q  <= last && verdict;
      hash_q <= last ? crc_nx[31:26] : 6'd0;
      if (take) begin
        cnt_q <= pos + 3'd1;
        crc_q <= crc_nx;
        bc_q  <= bc_nx;
        mc_q  <= mc_nx;
        uc_q  <= uc_nx;
      end
    end
  end

  assign done_o   = done_q;
  assign accept_o = acc_q;
  assign hash_o   = hash_q;

  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  a_r6_quiet_verdict: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> !accept_o);
  a_r1_promisc_accepts: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && $past(promisc_i) |-> accept_o);
  a_r5_unicast_needs_match: assert property (@(posedge clk) disable iff (!rst_n)
    accept_o && $past(!promisc_i && !bcast_en_i && !mcast_en_i) |-> $past(byte_i == sta_addr_i[47:40]));
  a_r7_done_follows_byte: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(byte_valid_i));

endmodule

// File: tb/tb_dst_addr_filter.sv
`timescale 1ns/1ps
module tb_dst_addr_filter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        promisc_i = 1'b0, bcast_en_i = 1'b0, mcast_en_i = 1'b0;
  logic [47:0] sta_addr_i = 48'h5544_3322_1100;
  logic [63:0] mcast_mask_i = '0;
  logic        byte_valid_i = 1'b0, first_i = 1'b0;
  logic [7:0]  byte_i = '0;
  logic        done_o, accept_o;
  logic [5:0]  hash_o;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  dst_addr_filter dut (.*);

  localparam logic [47:0] STA = 48'h5544_3322_1100;
  localparam logic [47:0] BC  = 48'hFFFF_FFFF_FFFF;
  localparam logic [47:0] MC1 = 48'h0000_005E_0001;
  localparam logic [47:0] MC2 = 48'hFFFF_FFFF_FF33;

  // {dest, promisc, mcast_en, bcast_en, mask mode, expected}
  // mask mode 0: zero, 1: only hash bit, 2: all but hash bit
  localparam logic [53:0] VEC [14] = '{
    {STA,                          3'b000, 2'd0, 1'b1},
    {STA ^ 48'h0100_0000_0000,     3'b000, 2'd0, 1'b0},
    {STA ^ 48'h0000_0000_0002,     3'b011, 2'd1, 1'b0},
    {BC,                           3'b001, 2'd0, 1'b1},
    {BC,                           3'b000, 2'd0, 1'b0},
    {BC,                           3'b010, 2'd1, 1'b0},
    {MC1,                          3'b010, 2'd1, 1'b1},
    {MC1,                          3'b010, 2'd2, 1'b0},
    {MC1,                          3'b001, 2'd1, 1'b0},
    {48'h1234_5678_9ABC,           3'b100, 2'd0, 1'b1},
    {MC1,                          3'b100, 2'd0, 1'b1},
    {MC2,                          3'b010, 2'd1, 1'b1},
    {MC2,                          3'b011, 2'd2, 1'b0},
    {STA,                          3'b011, 2'd0, 1'b1}
  };

  function automatic logic [5:0] ref_hash(input logic [47:0] d);
    logic [31:0] c;
    logic        cy;
    c = 32'hFFFF_FFFF;
    for (int k = 0; k < 6; k++)
      for (int i = 0; i < 8; i++) begin
        cy = c[31] ^ d[8*k+i];
        c  = {c[30:0], 1'b0};
        if (cy) c = (c ^ 32'h04C11DB6) | 32'd1;
      end
    return c[31:26];
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [47:0] d, input int gap, input bit with_first);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      byte_valid_i = 1'b1;
      first_i = with_first && k == 0;
      byte_i = d[8*k +: 8];
      for (int g = 0; g < gap; g++) begin
        if (k == 5) break;
        @(negedge clk);
        byte_valid_i = 1'b0;
        first_i = 1'b0;
        byte_i = 8'hA5;
      end
    end
    @(negedge clk);
    byte_valid_i = 1'b0;
    first_i = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R8 done after reset", done_o, 0);
    check("R8 accept after reset", accept_o, 0);
    check("R8 hash after reset", hash_o, 0);
    rst_n = 1'b1;

    for (int i = 0; i < 14; i++) begin
      logic [47:0] d;
      logic [5:0]  h;
      d = VEC[i][53:6];
      h = ref_hash(d);
      {promisc_i, mcast_en_i, bcast_en_i} = VEC[i][5:3];
      case (VEC[i][2:1])
        2'd0:    mcast_mask_i = '0;
        2'd1:    mcast_mask_i = 64'd1 << h;
        default: mcast_mask_i = ~(64'd1 << h);
      endcase
      send(d, i % 3, 1'b1);
      check("R6 done after sixth byte", done_o, 1);
      check($sformatf("R1 R2 R3 R5 verdict vector %0d", i), accept_o, VEC[i][0]);
      check($sformatf("R4 hash vector %0d", i), hash_o, h);
      @(negedge clk);
      check("R6 done single cycle", done_o, 0);
      check("R6 accept low without done", accept_o, 0);
    end

    // R7: bytes without a start marker are ignored
    {promisc_i, mcast_en_i, bcast_en_i} = 3'b100;
    send(STA, 0, 1'b0);
    check("R7 no done without start", done_o, 0);
    repeat (2) @(negedge clk);
    check("R7 still idle", done_o, 0);

    // R7: restart in the middle of a frame
    {promisc_i, mcast_en_i, bcast_en_i} = 3'b000;
    @(negedge clk);
    byte_valid_i = 1'b1; first_i = 1'b1; byte_i = 8'h77;
    @(negedge clk);
    byte_valid_i = 1'b1; first_i = 1'b0; byte_i = 8'h11;
    @(negedge clk);
    byte_valid_i = 1'b0;
    send(STA, 1, 1'b1);
    check("R7 restart gives done", done_o, 1);
    check("R7 restart accepts station", accept_o, 1);

    // R7: bytes after the sixth are ignored
    @(negedge clk);
    byte_valid_i = 1'b1; byte_i = 8'h00;
    repeat (7) @(negedge clk);
    check("R7 extra bytes ignored", done_o, 0);
    byte_valid_i = 1'b0;

    // R5: mismatch in a middle byte
    send(STA ^ 48'h0000_0080_0000, 0, 1'b1);
    check("R5 middle byte mismatch", accept_o, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule